// File: doc/BRIEF.md
# Trigger-Latched Multi-Channel PWM Controller

This block is a six-channel pulse-width modulator that sits behind a simple write-only register bus. For each channel, software writes a prescale value, a period count, an active (duty) count and a polarity into staging registers. None of these values reaches the running waveform until that channel's trigger bit goes from 0 to 1. The latched settings are then moved into the active copy in one of two ways. In immediate mode they are adopted after a fixed number of clock cycles. In smooth mode the block waits until the running period ends.

The block has no enable bit. To silence a channel, software commits a zero period, which holds the output at the inactive level for the chosen polarity. A channel whose trigger and smooth bits are both clear drives a constant high. A separate per-channel output-type bit is passed to the pad logic as a push-pull select.

Top module: `trig_pwm_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all registers are zero, every `pwm_out` bit is 1 and `pwm_pushpull` is 0.
- R2: A write to address 0x00 loads the per-channel control bits. Bit n is the trigger of channel n, bit 8+n its polarity, bit 16+n its output type and bit 24+n its smooth select. A write to 0x04 loads a 3-bit prescale for channel n at bits [4n+2:4n]. A write to 0x08+8n loads the 24-bit period of channel n, and a write to 0x0C+8n loads its 24-bit duty count.
- R3: With committed prescale s, period P > 0 and duty D < P, the output repeats every (s+1)·P clocks. It is active for the first (s+1)·D clocks of each repetition, counted from the commit edge.
- R4: A committed polarity of 1 drives the output high while active. A committed polarity of 0 drives it low while active and high otherwise.
- R5: Staged prescale, period, duty and polarity values do not change the output until a new 0-to-1 transition of the channel's trigger bit. Holding the trigger at 1 does not commit again.
- R6: If smooth is 0 when the trigger rises, the new settings take effect at the clock edge LATENCY+1 edges after the write that set the trigger. The counters restart at zero on that edge.
- R7: If smooth is 1 when the trigger rises, the new settings take effect on the first period boundary after the rise is detected, so the current period finishes unchanged.
- R8: While a channel's trigger and smooth bits are both 0, its output is forced to 1. Any other combination outputs the committed waveform.
- R9: A committed duty greater than or equal to the period keeps the output active for the whole period. A committed period of 0 holds the output at its inactive level.
- R10: `pwm_pushpull[n]` follows control bit 16+n one clock after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and counters |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Byte address of the register being written |
| wr_data | input | 32 | Write data |
| pwm_out | output | NCH (6) | One PWM output per channel |
| pwm_pushpull | output | NCH (6) | Per-channel push-pull select for the pad |

## Verification
A table of waveforms is committed in immediate mode on different channels. The entries cover a plain duty, a nonzero prescale, inverted polarity, duty at or above period, zero period in both polarities, and the smallest period with the largest prescale. Each trace is compared cycle by cycle from the commit edge, so a wrong tick rate, wrong phase or wrong inversion shows up as a mismatch. Directed sequences then separate the timing modes. The exact switch-over cycle distinguishes immediate from late commits. A staged change with the trigger held high must not appear. A smooth commit started mid-period must keep the old pattern up to the boundary, which an immediate commit would not. Toggling trigger and smooth shows the forced-high case apart from the committed inactive level.

// File: rtl/trig_pwm_pkg.sv
// Shared types and register layout for the trigger-latched PWM controller.
// Assumes at most eight channels, so each control field fits in one byte.
package trig_pwm_pkg;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 24;
    localparam int PRE_W      = 3;
    localparam int CTRL_ADDR  = 'h00;
    localparam int PRESC_ADDR = 'h04;
    localparam int CH_BASE    = 'h08;
    localparam int CH_STRIDE  = 8;
    localparam int DUTY_OFS   = 4;
    localparam int TRIG_LSB   = 0;
    localparam int POL_LSB    = 8;
    localparam int TYPE_LSB   = 16;
    localparam int SMOOTH_LSB = 24;
    localparam int PRESC_STEP = 4;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic             pol;
    } chan_cfg_t;
endpackage

// File: rtl/trig_pwm_regs.sv
// Register file: decodes bus writes into per-channel staging settings and
// control bits. Write-only; every register resets to zero.
module trig_pwm_regs
    import trig_pwm_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output chan_cfg_t [NCH-1:0]   stage_o,
    output logic [NCH-1:0]        trig_o,
    output logic [NCH-1:0]        smooth_o,
    output logic [NCH-1:0]        pushpull_o
);
    logic [NCH-1:0]   pol_q;
    logic [PRE_W-1:0] presc_q  [NCH];
    logic [CNT_W-1:0] period_q [NCH];
    logic [CNT_W-1:0] duty_q   [NCH];
    logic             unused_wdata;

    assign unused_wdata = ^wr_data;

    // Register writes, decoded per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o     <= '0;
            smooth_o   <= '0;
            pushpull_o <= '0;
            pol_q      <= '0;
            for (int i = 0; i < NCH; i++) begin
                presc_q[i]  <= '0;
                period_q[i] <= '0;
                duty_q[i]   <= '0;
            end
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
                trig_o     <= wr_data[TRIG_LSB   +: NCH];
                pol_q      <= wr_data[POL_LSB    +: NCH];
                pushpull_o <= wr_data[TYPE_LSB   +: NCH];
                smooth_o   <= wr_data[SMOOTH_LSB +: NCH];
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == ADDR_W'(PRESC_ADDR))
                    presc_q[i] <= wr_data[PRESC_STEP*i +: PRE_W];
                if (wr_addr == ADDR_W'(CH_BASE + CH_STRIDE*i))
                    period_q[i] <= wr_data[CNT_W-1:0];
                if (wr_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + DUTY_OFS))
                    duty_q[i] <= wr_data[CNT_W-1:0];
            end
        end
    end

    // Staging settings gathered per channel.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            stage_o[i].presc  = presc_q[i];
            stage_o[i].period = period_q[i];
            stage_o[i].duty   = duty_q[i];
            stage_o[i].pol    = pol_q[i];
        end
    end

    AST_CTRL_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> pushpull_o == $past(wr_data[TYPE_LSB +: NCH])); // R10
    AST_CTRL_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> trig_o == $past(wr_data[TRIG_LSB +: NCH])); // R2
endmodule

// File: rtl/trig_pwm_sched.sv
// Commit scheduler for one channel: detects the trigger rising edge against a
// registered copy, snapshots the staging settings and issues a commit either
// LATENCY cycles later (immediate) or on the next period boundary (smooth).
// Assumes LATENCY >= 1.
module trig_pwm_sched
    import trig_pwm_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig,
    input  logic      smooth,
    input  chan_cfg_t stage,
    input  logic      boundary,
    output logic      commit,
    output chan_cfg_t next_cfg
);
    localparam int WAIT_W = $clog2(LATENCY + 1);

    logic              trig_q;
    logic              rise;
    logic              pend_smooth;
    logic [WAIT_W-1:0] wait_cnt;

    assign rise   = trig && !trig_q;
    assign commit = (wait_cnt == WAIT_W'(1)) || (pend_smooth && boundary);

    // Edge history, pending snapshot and the commit timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q      <= 1'b0;
            pend_smooth <= 1'b0;
            wait_cnt    <= '0;
            next_cfg    <= '0;
        end else begin
            trig_q <= trig;
            if (rise) begin
                next_cfg    <= stage;
                pend_smooth <= smooth;
                wait_cnt    <= smooth ? '0 : WAIT_W'(LATENCY);
            end else if (commit) begin
                pend_smooth <= 1'b0;
                wait_cnt    <= '0;
            end else if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
            end
        end
    end

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WAIT_W'(LATENCY)); // R6
    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_smooth && wait_cnt != '0)); // R7
    AST_HELD_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && $past(trig) && !commit) |=> $stable(next_cfg)); // R5
endmodule

// File: rtl/trig_pwm_wave.sv
// Waveform generator for one channel: prescaler, period counter and output
// stage running from the active settings, which load only on commit.
// Output is forced high while trigger and smooth are both clear.
module trig_pwm_wave
    import trig_pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      commit,
    input  chan_cfg_t next_cfg,
    input  logic      trig,
    input  logic      smooth,
    output logic      boundary,
    output logic      pwm_o
);
    chan_cfg_t        act;
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             last;
    logic             on_phase;
    logic             wave;

    assign tick     = (pre_cnt == act.presc);
    assign last     = (act.period == '0) || (cnt == act.period - 1'b1);
    assign boundary = (act.period == '0) || (tick && last);

    // Active settings and counters; commit restarts both counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= '0;
            pre_cnt <= '0;
            cnt     <= '0;
        end else if (commit) begin
            act     <= next_cfg;
            pre_cnt <= '0;
            cnt     <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            cnt     <= last ? '0 : cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Output level from phase, polarity and the forced-high case.
    always_comb begin
        on_phase = (act.period != '0) && (cnt < act.duty);
        wave     = act.pol ? on_phase : !on_phase;
        pwm_o    = (!trig && !smooth) ? 1'b1 : wave;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (act.period != '0) |-> (cnt < act.period)); // R3
    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= act.presc); // R3
    AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act)); // R5
    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig || smooth) && act.period != '0 && act.duty >= act.period) |-> (pwm_o == act.pol)); // R9
    AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig || smooth) && act.period == '0) |-> (pwm_o == !act.pol)); // R9
    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !smooth) |-> pwm_o); // R8
endmodule

// File: rtl/trig_pwm_ctrl.sv
// Top of the trigger-latched PWM controller: one register file shared by
// NCH channels, each with its own commit scheduler and waveform generator.
// Assumes NCH <= 8 and LATENCY >= 1.
module trig_pwm_ctrl
    import trig_pwm_pkg::*;
#(
    parameter int NCH     = 6,
    parameter int LATENCY = 4,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    pwm_pushpull
);
    chan_cfg_t [NCH-1:0] stage;
    logic [NCH-1:0]      trig;
    logic [NCH-1:0]      smooth;

    trig_pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .stage_o    (stage),
        .trig_o     (trig),
        .smooth_o   (smooth),
        .pushpull_o (pwm_pushpull)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic      commit;
        logic      boundary;
        chan_cfg_t next_cfg;

        trig_pwm_sched #(.LATENCY(LATENCY)) u_sched (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig     (trig[ch]),
            .smooth   (smooth[ch]),
            .stage    (stage[ch]),
            .boundary (boundary),
            .commit   (commit),
            .next_cfg (next_cfg)
        );

        trig_pwm_wave u_wave (
            .clk      (clk),
            .rst_n    (rst_n),
            .commit   (commit),
            .next_cfg (next_cfg),
            .trig     (trig[ch]),
            .smooth   (smooth[ch]),
            .boundary (boundary),
            .pwm_o    (pwm_out[ch])
        );
    end
endmodule

// File: tb/trig_pwm_ctrl_tb.sv
module trig_pwm_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 6;
    localparam int LAT        = 4;
    localparam int WIN        = 40;

    typedef struct packed {
        logic [2:0]  ch;
        logic [2:0]  presc;
        logic [23:0] period;
        logic [23:0] duty;
        logic        pol;
    } vec_t;

    // ch, prescale, period, duty, polarity
    localparam vec_t TBL [7] = '{
        '{3'd0, 3'd0, 24'd8, 24'd3, 1'b1},
        '{3'd1, 3'd2, 24'd5, 24'd2, 1'b1},
        '{3'd2, 3'd1, 24'd6, 24'd2, 1'b0},
        '{3'd3, 3'd0, 24'd4, 24'd9, 1'b1},
        '{3'd4, 3'd0, 24'd0, 24'd0, 1'b1},
        '{3'd5, 3'd0, 24'd0, 24'd0, 1'b0},
        '{3'd0, 3'd7, 24'd2, 24'd1, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [NCH-1:0] pwm_out;
    logic [NCH-1:0] pwm_pushpull;

    int          n_checks = 0;
    int          n_fail   = 0;
    int          t        = 0;
    bit          done     = 0;
    logic [31:0] ctrl_sh  = '0;
    logic [31:0] presc_sh = '0;

    trig_pwm_ctrl #(.NCH(NCH), .LATENCY(LAT), .ADDR_W(8)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .pwm_out      (pwm_out),
        .pwm_pushpull (pwm_pushpull)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic model(input int s, input int per, input int duty,
                                   input logic pol, input int tt);
        logic on;
        on = (per != 0) && (((tt / (s + 1)) % per) < duty);
        return pol ? on : !on;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        t++;
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_addr = 8'(addr);
        wr_data = data;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic set_ctrl(input int ch, input bit trg, input bit smo, input bit pol);
        ctrl_sh[ch]      = trg;
        ctrl_sh[24 + ch] = smo;
        ctrl_sh[8 + ch]  = pol;
        bus_write('h00, ctrl_sh);
    endtask

    task automatic stage(input int ch, input int s, input int per, input int duty);
        presc_sh[4*ch +: 3] = 3'(s);
        bus_write('h04, presc_sh);
        bus_write('h08 + 8*ch, 32'(per));
        bus_write('h0C + 8*ch, 32'(duty));
    endtask

    // Stage, then commit in immediate mode; returns at the first negedge after the commit edge.
    task automatic commit_imm(input int ch, input int s, input int per, input int duty, input bit pol);
        set_ctrl(ch, 0, 1, pol);
        stage(ch, s, per, duty);
        set_ctrl(ch, 1, 0, pol);
        repeat (LAT + 1) tick();
        t = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int mism;
        int first_hi;
        int tc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check(pwm_out == 6'h3f, "R1", "pwm_out after reset", pwm_out, 6'h3f);
        check(pwm_pushpull == 6'h00, "R1", "pwm_pushpull after reset", pwm_pushpull, 0);

        // R10 and R2: output-type bits at 16+n
        ctrl_sh[16 +: NCH] = 6'h15;
        bus_write('h00, ctrl_sh);
        check(pwm_pushpull == 6'h15, "R10", "pushpull after ctrl write", pwm_pushpull, 6'h15);
        // R8: trigger and smooth still clear, so all outputs forced high
        check(pwm_out == 6'h3f, "R8", "forced high with type bits only", pwm_out, 6'h3f);

        // R3 R4 R9 R2: table of committed waveforms traced from the commit edge
        foreach (TBL[k]) begin
            int ch;
            int exp_v;
            ch = int'(TBL[k].ch);
            commit_imm(ch, int'(TBL[k].presc), int'(TBL[k].period), int'(TBL[k].duty), TBL[k].pol);
            mism = 0;
            exp_v = 0;
            for (int i = 0; i < WIN; i++) begin
                exp_v = int'(model(int'(TBL[k].presc), int'(TBL[k].period), int'(TBL[k].duty), TBL[k].pol, i));
                if (int'(pwm_out[ch]) != exp_v && mism == 0) begin
                    $display("FAIL R3 vector %0d cycle %0d: actual %0d expected %0d", k, i, pwm_out[ch], exp_v);
                end
                if (int'(pwm_out[ch]) != exp_v) mism++;
                tick();
            end
            check(mism == 0, "R3/R4/R9", $sformatf("table vector %0d mismatches", k), mism, 0);
        end

        // R6: channel 4 is idle low; commit constant high and find the switch cycle
        set_ctrl(4, 0, 1, 1);
        stage(4, 0, 3, 5);
        set_ctrl(4, 1, 0, 1);
        first_hi = -1;
        for (int i = 0; i <= LAT + 3; i++) begin
            if (pwm_out[4] && first_hi < 0) first_hi = i;
            tick();
        end
        check(first_hi == LAT + 1, "R6", "first cycle of new settings", first_hi, LAT + 1);

        // R5: trigger held high, staged zero period must not appear
        stage(4, 0, 0, 0);
        mism = 0;
        for (int i = 0; i < 20; i++) begin
            if (!pwm_out[4]) mism++;
            tick();
        end
        check(mism == 0, "R5", "low cycles with trigger held", mism, 0);
        set_ctrl(4, 0, 1, 1);
        check(pwm_out[4] == 1'b1, "R5", "falling trigger alone", pwm_out[4], 1);
        set_ctrl(4, 1, 0, 1);
        repeat (LAT + 1) tick();
        check(pwm_out[4] == 1'b0, "R5", "staged idle after new rise", pwm_out[4], 0);

        // R7: smooth commit on channel 5 from an 8-cycle pattern to constant high
        commit_imm(5, 0, 8, 4, 1);
        set_ctrl(5, 0, 1, 0);
        stage(5, 0, 0, 0);
        set_ctrl(5, 1, 1, 0);
        tc = (((t + 1) / 8) + 1) * 8;
        mism = 0;
        while (t < tc + 16) begin
            int exp_v;
            exp_v = (t >= tc) ? 1 : ((t % 8) < 4 ? 1 : 0);
            if (int'(pwm_out[5]) != exp_v) mism++;
            tick();
        end
        check(mism == 0, "R7", "smooth commit trace mismatches", mism, 0);

        // R8: channel 4 committed idle low; clearing both bits forces high
        set_ctrl(4, 0, 0, 1);
        check(pwm_out[4] == 1'b1, "R8", "both bits clear", pwm_out[4], 1);
        set_ctrl(4, 0, 1, 1);
        check(pwm_out[4] == 1'b0, "R8", "smooth set restores waveform", pwm_out[4], 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule